// File: doc/BRIEF.md
# Stereo Digital Silence Detector

This block watches a stereo stream of signed audio words. Each accepted transfer carries one left word and one right word. It counts the transfers in a row in which both words are exactly zero. Once that run reaches the configured length (511 by default), it pulls an active-low indicator pin low. The pin returns high on the first transfer that carries any nonzero bit on either channel.

The sample interface is valid/ready. The block never applies back-pressure: `smp_ready` is held high, so every cycle with `smp_valid` high delivers exactly one pair. Cycles without `smp_valid` carry no sample, and the values on the data inputs are then ignored.

Two plain control inputs shape the pin:
- A mode enable gates the function. While it is low, the pin drives a constant low, but the run count keeps tracking the stream.
- A one-cycle configuration strobe marks the first write of the device's operation register. Until that strobe arrives, the pin output-enable stays low, which leaves the pin high-impedance.

Top module: `silence_watch`

## Requirements
- R1: With the mode enable high and the output-enable high, `pin_out` goes low in the cycle after the 511th consecutive accepted pair whose left and right words are both zero. After only 510 such pairs it is still high.
- R2: An accepted pair with any nonzero bit in the left word or the right word ends the run. `pin_out` is high in the cycle after that pair, and a fresh run of 511 zero pairs is needed to go low again.
- R3: The run count saturates at 511. `pin_out` stays low through any longer stretch of zero pairs; it does not wrap and release.
- R4: Cycles with `smp_valid` low neither advance nor clear the run, whatever the data inputs hold. Idle gaps inside a run of zero pairs do not break it.
- R5: After reset, `pin_oe` is 0 and `pin_out` rests at 1. In the cycle after `cfg_strobe` is first seen high, `pin_oe` becomes 1, and it stays 1 until the next reset.
- R6: While `mode_en` is low and `pin_oe` is high, `pin_out` is 0, whatever the stream holds.
- R7: The run is tracked while `mode_en` is low and before configuration. When `mode_en` rises, or the output-enable comes on, after a complete run, `pin_out` is low at once, with no new run needed.
- R8: `smp_ready` is 1 in every cycle outside reset. Each cycle with `smp_valid` high is exactly one sample pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A sample pair is present this cycle |
| smp_ready | output | 1 | Always 1; the block accepts every pair |
| smp_left | input | SAMPLE_W | Left channel word |
| smp_right | input | SAMPLE_W | Right channel word |
| mode_en | input | 1 | Enables the silence function; when low, the pin drives 0 |
| cfg_strobe | input | 1 | Pulse on the first write of the operation register |
| pin_out | output | 1 | Active-low silence indicator; 0 means silence |
| pin_oe | output | 1 | Pin output-enable; 0 means high-impedance |

## Verification
The bench targets the following corner cases, and what a wrong design would show in each:

- **Run boundary.** The pin is checked after 510 zero pairs and again after 511. A counter that is off by one releases the pin one pair early or one pair late.
- **Long silence.** Several hundred further zero pairs follow a complete run. A wrapping counter would let the pin float back high partway through.
- **Nonzero on one channel.** Runs are broken by a value on the left channel only and on the right channel only. A design that tests just one channel, or that ANDs the values instead of their zero flags, stays low.
- **Idle gaps.** Gaps without `smp_valid`, with nonzero data present on the bus, are placed inside a run. They expose a design that counts clocks instead of samples, or that samples the bus without its strobe.
- **Mode and configuration timing.** A complete run is finished while the mode is off or before configuration. A design that freezes its counter in those states then needs a second full run.

// File: rtl/silence_pkg.sv
package silence_pkg;
  localparam int CHANNELS = 2;

  typedef enum int unsigned {
    CH_LEFT  = 0,
    CH_RIGHT = 1
  } chan_e;

  function automatic int cnt_width(input int limit);
    return $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/pair_zero_detect.sv
module pair_zero_detect
  import silence_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic [CHANNELS-1:0][SAMPLE_W-1:0] chans,
  output logic                              all_zero
);
  logic [CHANNELS-1:0] zero_bits;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    assign zero_bits[c] = ~|chans[c];
  end

  assign all_zero = &zero_bits;

  // R2: a set bit on any channel must clear the zero flag
  always_comb begin
    if (|chans[CH_LEFT] || |chans[CH_RIGHT])
      zero_flag_chk: assert (!all_zero) else $error("zero flag with nonzero data");
  end
endmodule

// File: rtl/run_counter.sv
module run_counter
  import silence_pkg::*;
#(
  parameter int RUN_LEN = 511,
  localparam int CW = cnt_width(RUN_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic pair_zero,
  output logic silent
);
  localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!take)                cnt_d = cnt_q;
    else if (!pair_zero)      cnt_d = '0;
    else if (cnt_q == LIMIT)  cnt_d = cnt_q;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign silent = (cnt_q == LIMIT);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  // R3
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (silent && take && pair_zero) |=> silent);

  // R2
  nonzero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !pair_zero) |=> (cnt_q == '0));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(cnt_q));

  // R1
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pair_zero && !silent) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pin_stage.sv
module pin_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_strobe,
  input  logic mode_en,
  input  logic silent,
  output logic pin_out,
  output logic pin_oe
);
  logic oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          oe_q <= 1'b0;
    else if (cfg_strobe) oe_q <= 1'b1;
  end

  always_comb begin
    if (!oe_q)         pin_out = 1'b1;
    else if (!mode_en) pin_out = 1'b0;
    else               pin_out = ~silent;
  end

  assign pin_oe = oe_q;

  // R5
  oe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |=> pin_oe);

  // R5
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_strobe |=> pin_oe);

  // R5
  park_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> pin_out);
endmodule

// File: rtl/silence_watch.sv
module silence_watch
  import silence_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int RUN_LEN  = 511
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                mode_en,
  input  logic                cfg_strobe,
  output logic                pin_out,
  output logic                pin_oe
);
  logic [CHANNELS-1:0][SAMPLE_W-1:0] chans;
  logic pair_zero, take, silent;

  assign smp_ready       = 1'b1;
  assign take            = smp_valid & smp_ready;
  assign chans[CH_LEFT]  = smp_left;
  assign chans[CH_RIGHT] = smp_right;

  pair_zero_detect #(.SAMPLE_W(SAMPLE_W)) u_zero (
    .chans    (chans),
    .all_zero (pair_zero)
  );

  run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .pair_zero (pair_zero),
    .silent    (silent)
  );

  pin_stage u_pin (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_strobe (cfg_strobe),
    .mode_en    (mode_en),
    .silent     (silent),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe)
  );

  // R8
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready);

  // R6
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && !mode_en) |-> !pin_out);

  // R2
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (|smp_left || |smp_right) && mode_en) ##1 (pin_oe && mode_en) |-> pin_out);
endmodule

// File: tb/silence_watch_bench.sv
module silence_watch_bench;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic smp_ready;
  logic [W-1:0] smp_left = '0, smp_right = '0;
  logic mode_en = 1'b1;
  logic cfg_strobe = 1'b0;
  logic pin_out, pin_oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  silence_watch #(.SAMPLE_W(W), .RUN_LEN(511)) u_silence_watch (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_left(smp_left), .smp_right(smp_right), .mode_en(mode_en),
    .cfg_strobe(cfg_strobe), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic send_pair(input logic [W-1:0] l, input logic [W-1:0] r);
    @(negedge clk);
    smp_valid = 1'b1; smp_left = l; smp_right = r;
    @(negedge clk);
    smp_valid = 1'b0; smp_left = '0; smp_right = '0;
  endtask

  task automatic send_zeros(input int n);
    for (int i = 0; i < n; i++) send_pair('0, '0);
  endtask

  task automatic pulse_cfg();
    @(negedge clk); cfg_strobe = 1'b1;
    @(negedge clk); cfg_strobe = 1'b0;
  endtask

  task automatic t_reset();
    chk("R5 reset oe", pin_oe, 1'b0);
    chk("R5 reset park", pin_out, 1'b1);
    chk("R8 ready", smp_ready, 1'b1);
  endtask

  task automatic t_preconfig();
    send_zeros(511);
    chk("R5 hz before cfg oe", pin_oe, 1'b0);
    chk("R5 park before cfg", pin_out, 1'b1);
    pulse_cfg();
    chk("R5 oe after cfg", pin_oe, 1'b1);
    chk("R7 run kept before cfg", pin_out, 1'b0);
    repeat (5) @(negedge clk);
    chk("R5 oe sticky", pin_oe, 1'b1);
    send_pair(24'h000001, '0);
    chk("R2 left nonzero release", pin_out, 1'b1);
  endtask

  task automatic t_boundary();
    send_zeros(510);
    chk("R1 after 510", pin_out, 1'b1);
    send_zeros(1);
    chk("R1 after 511", pin_out, 1'b0);
  endtask

  task automatic t_saturate();
    send_zeros(700);
    chk("R3 long silence", pin_out, 1'b0);
  endtask

  task automatic t_break();
    send_pair('0, 24'h800000);
    chk("R2 right nonzero release", pin_out, 1'b1);
    send_zeros(510);
    send_pair(24'h000040, '0);
    chk("R2 break near end", pin_out, 1'b1);
    send_zeros(510);
    chk("R2 fresh run 510", pin_out, 1'b1);
    send_zeros(1);
    chk("R2 fresh run 511", pin_out, 1'b0);
  endtask

  task automatic t_gaps();
    send_pair(24'h123456, 24'h654321);
    for (int i = 0; i < 510; i++) begin
      send_pair('0, '0);
      @(negedge clk); smp_left = 24'hABCDEF; smp_right = 24'h1;
      @(negedge clk); smp_left = '0; smp_right = '0;
    end
    chk("R4 gaps 510", pin_out, 1'b1);
    send_zeros(1);
    chk("R4 gaps 511", pin_out, 1'b0);
    @(negedge clk); smp_left = 24'hFFFFFF; smp_right = 24'hFFFFFF;
    repeat (20) @(negedge clk);
    smp_left = '0; smp_right = '0;
    chk("R4 idle bus ignored", pin_out, 1'b0);
  endtask

  task automatic t_mode();
    @(negedge clk); mode_en = 1'b0; #1;
    chk("R6 mode off silent", pin_out, 1'b0);
    send_pair(24'h5, 24'h5);
    chk("R6 mode off nonzero", pin_out, 1'b0);
    send_zeros(511);
    @(negedge clk); mode_en = 1'b1; #1;
    chk("R7 run kept while off", pin_out, 1'b0);
    send_pair(24'h9, '0);
    chk("R2 release mode on", pin_out, 1'b1);
    @(negedge clk); mode_en = 1'b0; #1;
    chk("R6 mode off not silent", pin_out, 1'b0);
    @(negedge clk); mode_en = 1'b1; #1;
    chk("R6 mode restored", pin_out, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_preconfig();
    t_boundary();
    t_saturate();
    t_break();
    t_gaps();
    t_mode();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule